// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A register-mapped watchdog built around a 16-bit down-counter. The counter advances on a slow tick made in two stages: an 8-bit programmable prescaler divides the clock by its value plus one, and a fixed divider then divides that by 16, 32, 64 or 128. When the counter passes zero it reloads from a separate reload register and fires the enabled actions: a sticky interrupt flag, a fixed-length reset pulse, or both.

Software keeps the system alive by rewriting the count register before it runs out. Any write to the clear address drops a pending interrupt. Turning off both the run bit and the reset-enable bit parks the block so that it can never reset the system. The bus is a simple single-cycle 32-bit port with an address, a write strobe, write data and combinational read data. One clock serves both the bus and the counter.

Top module: `guard_top`

## Requirements
- R1: After reset the control word reads 0x0000_8039 (prescaler 0x80, run on, divider select 3, interrupt off, reset on). Reload reads 0x8000 and count reads 0x8000. The interrupt and reset outputs are low.
- R2: While running, the count drops by one every (P+1)*D clock cycles. P is control bits 15:8 and D is the divider chosen by bits 4:3.
- R3: Divider select in control bits 4:3 picks D = 16, 32, 64 or 128 for the codes 0, 1, 2 and 3.
- R4: The tick that finds the count at zero loads the count from the reload register (offset 0x4) and marks an expiry.
- R5: On expiry with control bit 2 set, the interrupt output goes high and stays high until it is cleared. With bit 2 clear, an expiry leaves the interrupt output low.
- R6: Any write to offset 0xC clears the interrupt. A read of 0xC returns zero and leaves the interrupt unchanged.
- R7: On expiry with control bit 0 set, the reset output is high for exactly RST_LEN cycles.
- R8: A write to the count register (offset 0x8) loads the written low 16 bits on the next edge. This write takes priority over a tick in the same cycle, so periodic rewrites prevent any expiry.
- R9: With control bit 5 clear, the count does not change. With bits 5 and 0 both clear, the reset output stays low.
- R10: Every write to the control register (offset 0x0) restarts both divider stages from zero.
- R11: Control readback holds only bits 15:8, 5, 4:3, 2 and 0. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Sticky expiry interrupt |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with RST_LEN = 8, so the full reset pulse fits well inside one short tick period. It programs the prescaler to 0 or 1 with the small divider codes, which gives tick periods of 16 to 128 cycles. This makes repeated expiries, reload wrap-around, keepalive races and phase restarts reachable within a few hundred cycles. The power-up setting of a 129*128 cycle tick is checked only through its readback values.

// File: rtl/guard_pkg.sv
package guard_pkg;

  localparam logic [3:0] OFS_CTRL   = 4'h0;
  localparam logic [3:0] OFS_RELOAD = 4'h4;
  localparam logic [3:0] OFS_COUNT  = 4'h8;
  localparam logic [3:0] OFS_CLEAR  = 4'hC;

  typedef struct packed {
    logic [7:0] pre;
    logic       run;
    logic [1:0] div_sel;
    logic       irq_en;
    logic       rst_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pre: 8'h80, run: 1'b1, div_sel: 2'd3,
                                   irq_en: 1'b0, rst_en: 1'b1};

  // place the control fields at their bus positions
  function automatic logic [31:0] ctrl_to_word(ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[15:8]  = c.pre;
    w[5]     = c.run;
    w[4:3]   = c.div_sel;
    w[2]     = c.irq_en;
    w[0]     = c.rst_en;
    return w;
  endfunction

  function automatic ctrl_t word_to_ctrl(logic [31:0] w);
    ctrl_t c;
    c.pre     = w[15:8];
    c.run     = w[5];
    c.div_sel = w[4:3];
    c.irq_en  = w[2];
    c.rst_en  = w[0];
    return c;
  endfunction

  // last phase of the second stage: 16<<sel minus one
  function automatic logic [6:0] stage2_last(logic [1:0] sel);
    return 7'((16 << sel) - 1);
  endfunction

endpackage

// File: rtl/guard_regs.sv
module guard_regs
  import guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       addr,
  input  logic             we,
  input  logic [31:0]      wdata,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] reload,
  output logic             ctrl_wr,
  output logic             cnt_wr,
  output logic             clr_wr
);

  localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(1) << (CNT_W - 1);

  assign ctrl_wr = we && (addr == OFS_CTRL);
  assign cnt_wr  = we && (addr == OFS_COUNT);
  assign clr_wr  = we && (addr == OFS_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= CTRL_RESET;
      reload <= RELOAD_INIT;
    end else begin
      if (ctrl_wr)
        ctrl <= word_to_ctrl(wdata);
      if (we && (addr == OFS_RELOAD))
        reload <= wdata[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/guard_tick.sv
module guard_tick
  import guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  ctrl_wr,
  output logic  tick_pre,
  output logic  tick_cnt
);

  logic [7:0] pre_cnt;
  logic [6:0] div_cnt;
  logic       hold;
  logic       div_wrap;

  assign hold     = ctrl_wr || !ctrl.run;
  assign tick_pre = !hold && (pre_cnt == ctrl.pre);
  assign div_wrap = (div_cnt == stage2_last(ctrl.div_sel));
  assign tick_cnt = tick_pre && div_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (hold) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= tick_pre ? 8'd0 : pre_cnt + 8'd1;
      if (tick_pre)
        div_cnt <= div_wrap ? 7'd0 : div_cnt + 7'd1;
    end
  end

endmodule

// File: rtl/guard_core.sv
module guard_core #(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_cnt,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             clr_wr,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             rst_en,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             irq,
  output logic             rst_pulse
);

  localparam int PW = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] COUNT_INIT = CNT_W'(1) << (CNT_W - 1);

  logic [PW-1:0] pulse_left;

  assign expire    = tick_cnt && !cnt_wr && (count == '0);
  assign rst_pulse = (pulse_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= COUNT_INIT;
      irq        <= 1'b0;
      pulse_left <= '0;
    end else begin
      if (cnt_wr)
        count <= cnt_wdata;
      else if (tick_cnt)
        count <= (count == '0) ? reload : count - 1'b1;

      if (expire && irq_en)
        irq <= 1'b1;
      else if (clr_wr)
        irq <= 1'b0;

      if (!rst_en)
        pulse_left <= '0;
      else if (expire)
        pulse_left <= PW'(RST_LEN);
      else if (rst_pulse)
        pulse_left <= pulse_left - 1'b1;
    end
  end

endmodule

// File: rtl/guard_top.sv
module guard_top
  import guard_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        wdt_rst_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             ctrl_wr, cnt_wr, clr_wr;
  logic             tick_pre, tick_cnt, expire;

  guard_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .ctrl(ctrl), .reload(reload), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr),
    .clr_wr(clr_wr)
  );

  guard_tick u_tick (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ctrl_wr(ctrl_wr),
    .tick_pre(tick_pre), .tick_cnt(tick_cnt)
  );

  guard_core #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_cnt(tick_cnt), .cnt_wr(cnt_wr),
    .cnt_wdata(bus_wdata[CNT_W-1:0]), .clr_wr(clr_wr), .reload(reload),
    .irq_en(ctrl.irq_en), .rst_en(ctrl.rst_en), .count(count),
    .expire(expire), .irq(irq_o), .rst_pulse(wdt_rst_o)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:   bus_rdata = ctrl_to_word(ctrl);
      OFS_RELOAD: bus_rdata = 32'(reload);
      OFS_COUNT:  bus_rdata = 32'(count);
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_pre,
  input logic             tick_cnt,
  input logic             expire,
  input logic             run,
  input logic             cnt_wr,
  input logic             clr_wr,
  input logic [CNT_W-1:0] wval,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             irq,
  input logic             rst_out
);

  // R2
  cnt_tick_needs_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt |-> tick_pre);

  // R9
  halted_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick_pre);

  // R4
  expiry_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(reload)));

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !irq);

  // R7
  rst_after_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(expire));

  // R8
  keepalive_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(wval)));

endmodule

bind guard_top guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_pre(tick_pre), .tick_cnt(tick_cnt),
  .expire(expire), .run(ctrl.run), .cnt_wr(cnt_wr), .clr_wr(clr_wr),
  .wval(bus_wdata[CNT_W-1:0]), .count(count), .reload(reload),
  .irq(irq_o), .rst_out(wdt_rst_o)
);

// File: tb/tb_guard_top.sv
module tb_guard_top;

  localparam int RLEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'h8;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wdt_rst_o;

  int n_checks = 0;
  int n_fail   = 0;
  int rst_hi   = 0;

  // behavioural model state
  int m_ctrl, m_reload, m_cnt, m_pre, m_div, m_irq, m_pulse;

  guard_top #(.CNT_W(16), .RST_LEN(RLEN)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .wdt_rst_o(wdt_rst_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      0: return m_ctrl;
      4: return m_reload;
      8: return m_cnt;
      default: return 0;
    endcase
  endfunction

  // model step at each edge, compare 2 ns later
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 32'h8039; m_reload = 32'h8000; m_cnt = 32'h8000;
      m_pre = 0; m_div = 0; m_irq = 0; m_pulse = 0;
    end else begin
      int a, p, lim, en, t1, t2, ex, cw;
      a   = int'(bus_addr);
      cw  = (bus_we && a == 0) ? 1 : 0;
      en  = (m_ctrl >> 5) & 1;
      p   = (m_ctrl >> 8) & 255;
      lim = (16 << ((m_ctrl >> 3) & 3)) - 1;
      t1  = (en && !cw && m_pre == p) ? 1 : 0;
      t2  = (t1 && m_div == lim) ? 1 : 0;
      ex  = (t2 && m_cnt == 0 && !(bus_we && a == 8)) ? 1 : 0;
      if (cw || !en) begin m_pre = 0; m_div = 0; end
      else begin
        m_pre = (m_pre == p) ? 0 : m_pre + 1;
        if (t1) m_div = (m_div == lim) ? 0 : m_div + 1;
      end
      if (bus_we && a == 8) m_cnt = int'(bus_wdata & 32'hFFFF);
      else if (t2) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
      if (ex && ((m_ctrl >> 2) & 1)) m_irq = 1;
      else if (bus_we && a == 12) m_irq = 0;
      if (!(m_ctrl & 1)) m_pulse = 0;
      else if (ex) m_pulse = RLEN;
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (bus_we && a == 4) m_reload = int'(bus_wdata & 32'hFFFF);
      if (cw) m_ctrl = int'(bus_wdata & 32'hFF3D);
    end
    #2;
    if (rst_n) begin
      check("R2 model readback", bus_rdata, model_read(int'(bus_addr)));
      check("R5 model irq", irq_o, m_irq);
      check("R7 model reset pulse", wdt_rst_o, m_pulse != 0);
      if (wdt_rst_o) rst_hi++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'h8;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #3;
    d = bus_rdata;
    @(negedge clk);
    bus_addr = 4'h8;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, hold_cnt;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", irq_o, 0);
    check("R1 rst in reset", wdt_rst_o, 0);
    rst_n = 1'b1;
    rd(4'h0, v); check("R1 ctrl reset", v, 32'h8039);
    rd(4'h4, v); check("R1 reload reset", v, 32'h8000);
    rd(4'h8, v); check("R1 count reset", v, 32'h8000);
    check("R1 irq after reset", irq_o, 0);

    // R11 reserved bits
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R11 ctrl mask", v, 32'hFF3D);

    // R4 R5 R7 expiry, P=0, D=16, irq and reset enabled
    wr(4'h0, 32'h0025);
    wr(4'h4, 32'd2);
    wr(4'h8, 32'd3);
    rst_hi = 0;
    idle(90);
    check("R5 irq after expiry", irq_o, 1);
    check("R7 pulse length", rst_hi, RLEN);
    rd(4'h8, v); check("R4 count after reload", v, model_read(8));

    // R6 read of clear address has no effect
    rd(4'hC, v);
    check("R6 clear reads zero", v, 0);
    check("R6 read keeps irq", irq_o, 1);
    wr(4'hC, 32'h0);
    check("R6 write clears irq", irq_o, 0);

    // R8 keepalive
    wr(4'h0, 32'h0025);
    wr(4'hC, 32'h1);
    rst_hi = 0;
    for (int i = 0; i < 15; i++) begin
      wr(4'h8, 32'h0005);
      idle(20);
    end
    check("R8 no irq under keepalive", irq_o, 0);
    check("R8 no reset under keepalive", rst_hi, 0);

    // R5 expiry without interrupt enable
    wr(4'h0, 32'h0021);
    wr(4'h8, 32'd1);
    idle(60);
    check("R5 no irq when disabled", irq_o, 0);

    // R3 divider 64, prescaler 1: 128 cycles per tick
    wr(4'h0, 32'h0130);
    wr(4'h8, 32'd10);
    idle(300);
    rd(4'h8, v); check("R3 count with div64", v, 8);

    // R10 control rewrites hold the phase
    wr(4'h0, 32'h0020);
    wr(4'h8, 32'd100);
    for (int i = 0; i < 10; i++) begin
      idle(10);
      wr(4'h0, 32'h0020);
    end
    rd(4'h8, v); check("R10 phase restart", v, 100);

    // R9 halted
    wr(4'h0, 32'h0000);
    rd(4'h8, hold_cnt);
    rst_hi = 0;
    idle(300);
    rd(4'h8, v); check("R9 frozen count", v, hold_cnt);
    check("R9 no reset when halted", rst_hi, 0);
    wr(4'h0, 32'h0004);
    idle(100);
    rd(4'h8, v); check("R9 frozen with irq enable", v, hold_cnt);

    idle(5);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule